// File: doc/BRIEF.md
# Fractional Microsecond Timebase Counter

The block turns a fast input clock into a steady stream of one-cycle microsecond strobes and keeps a running count of them. The input clock may run at a rate that is not a whole number of megahertz (12.8 MHz or 19.2 MHz, for example). To handle such rates, software programs a rational ratio: a count of input clocks against a count of microseconds. The block then spreads the strobes so that their long-run average is exactly 1 MHz. No PLL is involved. A small phase accumulator gains the microsecond term on every input clock, and it gives up the clock term each time it issues a strobe.

Software reaches the block through a simple synchronous register port. One register holds the 16-bit ratio. One read-only register returns the free-running 32-bit microsecond count. A freeze control stops both the count and the strobe without losing the accumulator phase. Other timers in the chip take the strobe as their 1 MHz enable.

Top module: `usec_timebase`

## Requirements
- R1: After a synchronous active-high reset, the count reads 0, the ratio register reads 0x0000000b, the freeze register reads 0, and the tick output is low.
- R2: The ratio register sits at offset 0x14. Bits 7:0 hold (input clocks per period − 1) and bits 15:8 hold (microseconds per period − 1). It reads back in bits 15:0, with bits 31:16 reading zero.
- R3: With the microsecond term M = bits 15:8 + 1 no larger than the clock term C = bits 7:0 + 1, exactly floor(n·M/C) ticks occur over the first n active clocks after a phase start. A phase starts at reset or at a ratio write.
- R4: At most one tick is issued per input clock. When M exceeds C, a tick is issued on every active clock.
- R5: The count at offset 0x10 advances by exactly one in each clock that raises the tick output, and wraps modulo 2^32. Writes to offset 0x10 have no effect.
- R6: Freeze is bit 0 at offset 0x4c and takes effect from the clock after its write. While it is set, the count holds, the tick stays low, and the accumulator phase is kept, so counting resumes from the same phase once freeze is cleared.
- R7: A write to the ratio register clears the accumulator, and no tick is issued in the clock of that write.
- R8: Reads of any other offset return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| usec_tick | output | 1 | One-cycle microsecond strobe |

## Verification
Two events can fall in the same clock: a ratio write and an accumulator overflow, or a freeze and a pending tick. The bench provokes the first case by rewriting the ratio just one clock before a tick is due. It then checks that the tick is deferred by a full new period rather than issued. It provokes the second by setting freeze partway through a period, then counting clocks across the frozen gap. A counter that restarted its phase on unfreeze would come up one tick short.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    localparam int RATIO_W   = 8;
    localparam int ACC_W     = RATIO_W + 1;
    localparam int SUM_W     = RATIO_W + 2;

    localparam logic [7:0] OFF_COUNT  = 8'h10;
    localparam logic [7:0] OFF_RATIO  = 8'h14;
    localparam logic [7:0] OFF_FREEZE = 8'h4c;

    typedef struct packed {
        logic [RATIO_W-1:0] usec_m1;
        logic [RATIO_W-1:0] clk_m1;
    } ratio_cfg_t;

    localparam ratio_cfg_t RATIO_RESET = '{usec_m1: 8'h00, clk_m1: 8'h0b};

    function automatic logic [ACC_W-1:0] ratio_usec(input ratio_cfg_t r);
        return {1'b0, r.usec_m1} + ACC_W'(1);
    endfunction

    function automatic logic [ACC_W-1:0] ratio_clks(input ratio_cfg_t r);
        return {1'b0, r.clk_m1} + ACC_W'(1);
    endfunction

endpackage

// File: rtl/ubt_regs.sv
module ubt_regs
    import ubt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output ratio_cfg_t        ratio,
    output logic              freeze,
    output logic              ratio_wr,
    output logic [DATA_W-1:0] rdata
);
    localparam int CFG_W = 2 * RATIO_W;

    logic freeze_wr;
    logic unused_wdata_hi;

    assign ratio_wr  = we && (addr == ADDR_W'(OFF_RATIO));
    assign freeze_wr = we && (addr == ADDR_W'(OFF_FREEZE));
    assign unused_wdata_hi = ^wdata[DATA_W-1:CFG_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio  <= RATIO_RESET;
            freeze <= 1'b0;
        end else begin
            if (ratio_wr)  ratio  <= ratio_cfg_t'(wdata[CFG_W-1:0]);
            if (freeze_wr) freeze <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_COUNT))       rdata = DATA_W'(count);
        else if (addr == ADDR_W'(OFF_RATIO))  rdata = DATA_W'(ratio);
        else if (addr == ADDR_W'(OFF_FREEZE)) rdata = DATA_W'(freeze);
    end

    // R2: a ratio write lands in the register on the next clock
    assert_ratio_load_R2: assert property (@(posedge clk) disable iff (rst)
        ratio_wr |=> ratio == ratio_cfg_t'($past(wdata[CFG_W-1:0])));

    // R8: without a matching write the registers keep their value
    assert_regs_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(ratio) && $stable(freeze));

endmodule

// File: rtl/ubt_phase_accum.sv
module ubt_phase_accum
    import ubt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] usec_step,
    input  logic [ACC_W-1:0] clk_span,
    input  logic             hold,
    input  logic             restart,
    output logic             fire
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] rem;
    logic             overflow;

    assign sum      = SUM_W'(acc_q) + SUM_W'(usec_step);
    assign overflow = sum >= SUM_W'(clk_span);
    assign rem      = sum - SUM_W'(clk_span);
    assign fire     = overflow && !hold && !restart;

    always_comb begin
        acc_d = acc_q;
        if (restart) begin
            acc_d = '0;
        end else if (!hold) begin
            if (!overflow)
                acc_d = sum[ACC_W-1:0];
            else if (rem >= SUM_W'(clk_span))
                acc_d = clk_span - ACC_W'(1);
            else
                acc_d = rem[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    // R4: the residue stays below one clock span, so one tick per clock suffices
    assert_acc_below_span_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(restart) |-> acc_q < clk_span);

    // R6: a held accumulator keeps its phase
    assert_phase_kept_R6: assert property (@(posedge clk) disable iff (rst)
        hold && !restart |=> $stable(acc_q));

    // R7: a ratio write restarts the phase from zero
    assert_phase_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> acc_q == '0);

endmodule

// File: rtl/ubt_us_counter.sv
module ubt_us_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    output logic             tick,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tick  <= 1'b0;
            count <= '0;
        end else begin
            tick <= fire;
            if (fire) count <= count + CNT_W'(1);
        end
    end

    // R5: each tick adds exactly one, wrapping at full width
    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        fire |=> count == $past(count) + CNT_W'(1));

    // R5: no tick, no change
    assert_count_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(count));

endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
    import ubt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              usec_tick
);
    ratio_cfg_t       ratio;
    logic             freeze;
    logic             ratio_wr;
    logic             fire;
    logic [CNT_W-1:0] count;

    ubt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .count    (count),
        .ratio    (ratio),
        .freeze   (freeze),
        .ratio_wr (ratio_wr),
        .rdata    (bus_rdata)
    );

    ubt_phase_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .usec_step (ratio_usec(ratio)),
        .clk_span  (ratio_clks(ratio)),
        .hold      (freeze),
        .restart   (ratio_wr),
        .fire      (fire)
    );

    ubt_us_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .tick  (usec_tick),
        .count (count)
    );

    // R6: frozen clocks raise no tick
    assert_frozen_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
        freeze |=> !usec_tick);

    // R7: the clock of a ratio write raises no tick
    assert_write_no_tick_R7: assert property (@(posedge clk) disable iff (rst)
        ratio_wr |=> !usec_tick);

endmodule

// File: tb/usec_timebase_test.sv
module usec_timebase_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h10;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        usec_tick;

    int checks = 0;
    int failures = 0;
    int ticks_seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    usec_timebase uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .usec_tick(usec_tick)
    );

    always @(negedge clk) if (!rst && usec_tick) ticks_seen++;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=0x%08h expected=0x%08h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h10;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata; bus_addr = 8'h10; #1;
    endtask

    function automatic int exp_ticks(input int n, input logic [15:0] cfg);
        int m = int'(cfg[15:8]) + 1;
        int c = int'(cfg[7:0]) + 1;
        int f = (n * m) / c;
        return (f > n) ? n : f;
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        step(3);
        rd(8'h10, v); check("R1 count", v, 32'h0);
        rd(8'h14, v); check("R1 ratio", v, 32'h0000000b);
        rd(8'h4c, v); check("R1 freeze", v, 32'h0);
        check("R1 tick", {31'b0, usec_tick}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_default;
        logic [31:0] v;
        int t0 = ticks_seen;
        step(120);
        rd(8'h10, v); check("R3 default 12 clocks/us count", v, 32'd10);
        check("R5 ticks match count", ticks_seen - t0, 32'd10);
    endtask

    task automatic t_ratio(input logic [15:0] cfg, input int n);
        logic [31:0] c0, c1;
        int t0;
        wr(8'h14, {16'h0, cfg});
        rd(8'h14, c0); check("R2 ratio readback", c0, {16'h0, cfg});
        rd(8'h10, c0);
        t0 = ticks_seen;
        step(n);
        rd(8'h10, c1);
        check("R3 fractional count", c1 - c0, exp_ticks(n, cfg));
        check("R5 one count per tick", ticks_seen - t0, c1 - c0);
    endtask

    task automatic t_fast;
        logic [31:0] c0, c1;
        int hi = 0;
        wr(8'h14, 32'h0201);
        rd(8'h10, c0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (usec_tick) hi++;
        end
        rd(8'h10, c1);
        check("R4 tick every clock", hi, 32'd20);
        check("R4 one per clock", c1 - c0, 32'd20);
    endtask

    task automatic t_restart;
        logic [31:0] c0, v;
        wr(8'h14, 32'h000b);
        rd(8'h10, c0);
        step(11);
        wr(8'h14, 32'h000b);
        rd(8'h10, v); check("R7 no tick on write clock", v - c0, 32'd0);
        step(11);
        rd(8'h10, v); check("R7 phase cleared", v - c0, 32'd0);
        step(1);
        rd(8'h10, v); check("R7 first tick after full period", v - c0, 32'd1);
    endtask

    task automatic t_freeze;
        logic [31:0] c0, v;
        int t0;
        wr(8'h14, 32'h000b);
        rd(8'h10, c0);
        step(17);
        wr(8'h4c, 32'h1);
        rd(8'h4c, v); check("R6 freeze readback", v, 32'h1);
        rd(8'h10, v); check("R6 count before freeze", v - c0, 32'd1);
        t0 = ticks_seen;
        step(40);
        wr(8'h10, 32'hdeadbeef);
        rd(8'h10, v); check("R5 count write ignored", v - c0, 32'd1);
        check("R6 no tick while frozen", ticks_seen - t0, 32'd0);
        wr(8'h4c, 32'h0);
        step(30);
        rd(8'h10, v); check("R6 phase kept across freeze", v - c0, 32'd4);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(8'h14, 32'h045f);
        wr(8'h20, 32'hffffffff);
        rd(8'h20, v); check("R8 unmapped reads zero", v, 32'h0);
        rd(8'h14, v); check("R8 ratio untouched", v, 32'h045f);
        rd(8'h4c, v); check("R8 freeze untouched", v, 32'h0);
        wr(8'h14, 32'hffff043f);
        rd(8'h14, v); check("R2 upper bits read zero", v, 32'h043f);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_default;
        t_ratio(16'h043f, 700);
        t_ratio(16'h002f, 480);
        t_ratio(16'h045f, 1000);
        t_ratio(16'h0453, 850);
        t_fast;
        t_restart;
        t_freeze;
        t_unmapped;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog got=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule